// File: doc/BRIEF.md
# Copy-Protection Scramble and PRG Override Unit

This unit sits beside a cartridge bank controller and snoops CPU writes. Two kinds of writes reach it. Writes into the 0x5000–0x5FFF expansion window load a small readable protection latch from a fixed lookup. Some of those writes also load an outer bank register. Writes into the 0x8000–0x9FFF command window feed a scrambler. A bank-data write is bit-reversed into a 6-bit scramble register. A mode write selects the rule that decides what happens to that value.

A mode decode runs in the same cycle as the write that triggers it. It may copy the scramble value into one of three PRG override registers. It may also set or clear a lock flag. While the lock flag is set, later bank-data writes do not cause a decode. The PRG bank mapper receives the three override windows, each already merged with the outer bank bit at bank bit 5. It also receives a mode-active flag and the outer bank bit itself. It uses these to replace the banks at 0xE000, 0xC000 and 0xA000.

Top module: `prot_scramble`

## Requirements
- R1: After reset the protection latch is 0x00, the outer register is 0x80, the mode register, the lock flag, the scramble register and all overrides are 0. So `mode_active`=0, `outer_hi`=1, and each window output is 0x20.
- R2: `rd_data` shows the protection latch when `cpu_re` is high and `cpu_addr[15:12]`=0x5. At all other times `rd_data` is 0x00.
- R3: A write with `cpu_addr[15:12]`=0x5 loads the latch with a value taken from `cpu_din[1:0]`: 0→0x83, 1→0x83, 2→0x42, 3→0x00.
- R4: A write in that window where `(cpu_addr & 0x5180)==0x5180` also stores the full data byte in the outer register. `outer_hi` is bit 7 of that register. Any other expansion write leaves the outer register unchanged.
- R5: A write where `(cpu_addr & 0xE003)==0x8001` stores `cpu_din[5:0]` bit-reversed in the scramble register: din bit i goes to bit 5−i. A mode decode follows only if the lock flag was clear before the write.
- R6: While the lock flag is set, writes to 0x8001 change no override.
- R7: A write where `(cpu_addr & 0xE003)==0x8003` stores the full byte in the mode register. A decode then always follows, using the current scramble value.
- R8: A decode of mode[5:0] equal to 0x20, 0x29, 0x2B, 0x3C or 0x3F sets the lock flag and copies the scramble value into override 0.
- R9: A decode of 0x2C sets the lock flag. It copies the scramble value into override 0 only when that value is nonzero.
- R10: A decode of 0x26 clears the lock flag and copies into override 0. A decode of 0x28 does the same into override 1, and 0x2A into override 2.
- R11: A decode of 0x2F changes nothing. A decode of any mode[5:0] value not listed in R8–R10 clears the whole mode register to 0.
- R12: `mode_active` = OR of mode[5:0]. `win_e`, `win_c` and `win_a` are overrides 0, 1 and 2 with bit 5 ORed with outer bit 7. They are driven whether or not the mode is active.
- R13: A write to any other address changes no output. Examples are 0x8000, 0x8002, 0xA001 and 0x6000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_din | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| cpu_re | input | 1 | Read strobe |
| rd_data | output | 8 | Protection latch read value |
| win_e | output | 6 | Override bank for 0xE000 window |
| win_c | output | 6 | Override bank for 0xC000 window |
| win_a | output | 6 | Override bank for 0xA000 window |
| mode_active | output | 1 | Mode register low six bits nonzero |
| outer_hi | output | 1 | Outer bank register bit 7 |

## Verification
The lock flag and the scramble register cannot be read directly. Their effect shows only through which override moves, or fails to move, on a later write. The hardest case is a locked 0x8001 write that must leave every window unchanged. A second hard case is 0x2C against a zero scramble value. Directed sequences first unlock with 0x26, then load a known scramble value, then lock. They then send bank-data and mode writes and check that the overrides hold. Random traffic is weighted toward the valid mode codes so that lock and unlock transitions occur often, and every write is compared against a bench model.

// File: rtl/prot_scramble.sv
module prot_scramble #(
  parameter logic [7:0] OUTER_RST = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_din,
  input  logic        cpu_we,
  input  logic        cpu_re,
  output logic [7:0]  rd_data,
  output logic [5:0]  win_e,
  output logic [5:0]  win_c,
  output logic [5:0]  win_a,
  output logic        mode_active,
  output logic        outer_hi
);

  logic [7:0] latch_q, outer_q, mode_q;
  logic [7:0] mode_n;
  logic       lock_q, lock_n;
  logic [5:0] scr_q, scr_n;
  logic [5:0] ov0_q, ov1_q, ov2_q, ov0_n, ov1_n, ov2_n;
  logic       run;

  wire exp_hit  = cpu_addr[15:12] == 4'h5;
  wire exp_wr   = cpu_we & exp_hit;
  wire outer_wr = exp_wr & ((cpu_addr & 16'h5180) == 16'h5180);
  wire cmd_hit  = cpu_we & (cpu_addr[15:13] == 3'b100);
  wire scr_wr   = cmd_hit & (cpu_addr[1:0] == 2'b01);
  wire mode_wr  = cmd_hit & (cpu_addr[1:0] == 2'b11);

  function automatic logic [5:0] rev6(input logic [5:0] v);
    for (int i = 0; i < 6; i++) rev6[i] = v[5-i];
  endfunction

  function automatic logic [7:0] prot_val(input logic [1:0] s);
    case (s)
      2'd0, 2'd1: prot_val = 8'h83;
      2'd2:       prot_val = 8'h42;
      default:    prot_val = 8'h00;
    endcase
  endfunction

  always_comb begin
    scr_n  = scr_wr ? rev6(cpu_din[5:0]) : scr_q;
    mode_n = mode_wr ? cpu_din : mode_q;
    lock_n = lock_q;
    ov0_n  = ov0_q;
    ov1_n  = ov1_q;
    ov2_n  = ov2_q;
    run    = mode_wr | (scr_wr & ~lock_q);
    if (run) begin
      case (mode_n[5:0])
        6'h20, 6'h29, 6'h2B, 6'h3C, 6'h3F: begin lock_n = 1'b1; ov0_n = scr_n; end
        6'h26: begin lock_n = 1'b0; ov0_n = scr_n; end
        6'h2C: begin lock_n = 1'b1; if (scr_n != 6'd0) ov0_n = scr_n; end
        6'h28: begin lock_n = 1'b0; ov1_n = scr_n; end
        6'h2A: begin lock_n = 1'b0; ov2_n = scr_n; end
        6'h2F: ;
        default: mode_n = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 8'h00;
      outer_q <= OUTER_RST;
      mode_q  <= 8'h00;
      lock_q  <= 1'b0;
      scr_q   <= 6'd0;
      ov0_q   <= 6'd0;
      ov1_q   <= 6'd0;
      ov2_q   <= 6'd0;
    end else begin
      if (exp_wr)   latch_q <= prot_val(cpu_din[1:0]);
      if (outer_wr) outer_q <= cpu_din;
      mode_q <= mode_n;
      lock_q <= lock_n;
      scr_q  <= scr_n;
      ov0_q  <= ov0_n;
      ov1_q  <= ov1_n;
      ov2_q  <= ov2_n;
    end
  end

  assign rd_data     = (cpu_re & exp_hit) ? latch_q : 8'h00;
  assign outer_hi    = outer_q[7];
  assign mode_active = |mode_q[5:0];
  assign win_e       = ov0_q | {outer_q[7], 5'd0};
  assign win_c       = ov1_q | {outer_q[7], 5'd0};
  assign win_a       = ov2_q | {outer_q[7], 5'd0};

endmodule

// File: rtl/prot_scramble_chk.sv
module prot_scramble_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_din,
  input logic        cpu_we,
  input logic        cpu_re,
  input logic [7:0]  rd_data,
  input logic [5:0]  win_e,
  input logic [5:0]  win_c,
  input logic [5:0]  win_a,
  input logic        mode_active,
  input logic        outer_hi
);

  wire exp_rd    = cpu_re && (cpu_addr[15:12] == 4'h5);
  wire outer_sel = cpu_we && ((cpu_addr & 16'h5180) == 16'h5180) && (cpu_addr[15:12] == 4'h5);
  wire bad_mode  = cpu_we && ((cpu_addr & 16'hE003) == 16'h8003) &&
                   !(cpu_din[5:0] inside {6'h20, 6'h26, 6'h28, 6'h29, 6'h2A, 6'h2B,
                                          6'h2C, 6'h2F, 6'h3C, 6'h3F});

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !exp_rd |-> rd_data == 8'h00); // R2

  AST_RD_TABLE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    exp_rd |-> rd_data inside {8'h00, 8'h42, 8'h83}); // R3

  AST_OUTER_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(outer_sel) |-> $stable(outer_hi)); // R4

  AST_BAD_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |=> !mode_active); // R11

  AST_OUTER_BIT5: assert property (@(posedge clk) disable iff (!rst_n)
    outer_hi |-> (win_e[5] && win_c[5] && win_a[5])); // R12

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cpu_we) |-> ($stable(win_e) && $stable(win_c) && $stable(win_a) && $stable(mode_active))); // R13

endmodule

bind prot_scramble prot_scramble_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
  .cpu_we(cpu_we), .cpu_re(cpu_re), .rd_data(rd_data), .win_e(win_e),
  .win_c(win_c), .win_a(win_a), .mode_active(mode_active), .outer_hi(outer_hi)
);

// File: tb/sim_prot_scramble.sv
module sim_prot_scramble;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_din = 8'h00;
  logic        cpu_we = 1'b0;
  logic        cpu_re = 1'b0;
  logic [7:0]  rd_data;
  logic [5:0]  win_e, win_c, win_a;
  logic        mode_active, outer_hi;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] m_latch, m_outer, m_mode;
  logic       m_lock;
  logic [5:0] m_scr, m_ov0, m_ov1, m_ov2;

  always #2.5 clk = ~clk;

  prot_scramble u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .rd_data(rd_data), .win_e(win_e),
    .win_c(win_c), .win_a(win_a), .mode_active(mode_active), .outer_hi(outer_hi)
  );

  function automatic logic [7:0] exp_prot(input logic [1:0] s);
    return (s == 2'd2) ? 8'h42 : (s == 2'd3) ? 8'h00 : 8'h83;
  endfunction

  function automatic logic [5:0] exp_rev(input logic [5:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[5-i] = v[i];
    return r;
  endfunction

  task automatic model_reset();
    m_latch = 8'h00; m_outer = 8'h80; m_mode = 8'h00; m_lock = 1'b0;
    m_scr = 6'd0; m_ov0 = 6'd0; m_ov1 = 6'd0; m_ov2 = 6'd0;
  endtask

  task automatic model_decode();
    case (m_mode[5:0])
      6'h20, 6'h29, 6'h2B, 6'h3C, 6'h3F: begin m_lock = 1'b1; m_ov0 = m_scr; end
      6'h26: begin m_lock = 1'b0; m_ov0 = m_scr; end
      6'h2C: begin m_lock = 1'b1; if (m_scr != 0) m_ov0 = m_scr; end
      6'h28: begin m_lock = 1'b0; m_ov1 = m_scr; end
      6'h2A: begin m_lock = 1'b0; m_ov2 = m_scr; end
      6'h2F: ;
      default: m_mode = 8'h00;
    endcase
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (a[15:12] == 4'h5) begin
      m_latch = exp_prot(d[1:0]);
      if ((a & 16'h5180) == 16'h5180) m_outer = d;
    end
    if ((a & 16'hE003) == 16'h8001) begin
      logic was_locked;
      was_locked = m_lock;
      m_scr = exp_rev(d[5:0]);
      if (!was_locked) model_decode();
    end
    if ((a & 16'hE003) == 16'h8003) begin
      m_mode = d;
      model_decode();
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    logic [5:0] hb;
    hb = {m_outer[7], 5'd0};
    chk(tag, {win_e, win_c, win_a, mode_active, outer_hi},
        {m_ov0 | hb, m_ov1 | hb, m_ov2 | hb, |m_mode[5:0], m_outer[7]});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_din = d; cpu_we = 1'b1;
    model_write(a, d);
    @(negedge clk);
    cpu_we = 1'b0;
    #1;
    chk_outs(tag);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_re = 1'b1;
    #1;
    chk(tag, rd_data, (a[15:12] == 4'h5) ? m_latch : 8'h00);
    cpu_re = 1'b0;
    #1;
    chk(tag, rd_data, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [7:0] d;
    int unsigned seed;
    seed = 32'h1234abcd;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_outs("R1 reset state");
    chk("R1 reset win_e", win_e, 6'h20);
    rd(16'h5000, "R1 reset latch");

    for (int i = 0; i < 4; i++) begin
      wr(16'h5000 + 16'(i * 16'h111), 8'(i) | 8'hF0, "R3 table write");
      rd(16'h5ABC, "R3 table read");
    end
    rd(16'h4FFF, "R2 outside window");
    rd(16'h6000, "R2 outside window high");

    wr(16'h5180, 8'h00, "R4 outer load");
    chk("R4 outer low", outer_hi, 1'b0);
    wr(16'h5100, 8'h80, "R4 outer no match");
    chk("R4 outer kept", outer_hi, 1'b0);
    wr(16'h5FFF, 8'h80, "R4 outer match high");
    chk("R4 outer high", outer_hi, 1'b1);
    wr(16'h5180, 8'h00, "R4 outer clear");

    wr(16'h8003, 8'h26, "R10 mode 26");
    wr(16'h8001, 8'h01, "R5 reverse 01");
    chk("R5 reverse 01 to 20", win_e, 6'h20);
    wr(16'h9FFD, 8'h06, "R5 reverse mirror addr");
    chk("R5 reverse 06 to 18", win_e, 6'h18);
    wr(16'h8003, 8'h28, "R10 mode 28");
    chk("R10 ov1", win_c, 6'h18);
    wr(16'h8003, 8'h2A, "R10 mode 2A");
    chk("R10 ov2", win_a, 6'h18);

    wr(16'h8001, 8'h3F, "R10 2A unlocked capture");
    wr(16'h8003, 8'h20, "R8 mode 20 lock");
    chk("R8 ov0 capture", win_e, 6'h3F);
    wr(16'h8001, 8'h01, "R6 locked write");
    chk("R6 ov0 hold", win_e, 6'h3F);
    wr(16'h8003, 8'h29, "R8 mode 29");
    chk("R8 ov0 after 29", win_e, 6'h20);

    wr(16'h8003, 8'h26, "R7 unlock");
    wr(16'h8001, 8'h00, "R9 zero scr");
    wr(16'h8003, 8'h2F, "R11 mode 2F nothing");
    wr(16'h8001, 8'h02, "R11 2F no capture");
    chk("R11 2F keeps ov0", win_e, 6'h00);
    wr(16'h8003, 8'h26, "R7 mode write decodes");
    chk("R7 ov0 from scr", win_e, 6'h10);
    wr(16'h8001, 8'h00, "R9 scr zero");
    wr(16'h8001, 8'h04, "R9 scr 08");
    wr(16'h8001, 8'h00, "R9 scr back to zero");
    chk("R9 ov0 zero via 26", win_e, 6'h00);
    wr(16'h8001, 8'h04, "R9 prime");
    wr(16'h8003, 8'h2C, "R9 2C nonzero");
    chk("R9 2C copies", win_e, 6'h08);
    wr(16'h8003, 8'h26, "R9 unlock");
    wr(16'h8003, 8'h2F, "R9 park");
    wr(16'h8001, 8'h00, "R9 scr zero under 2F");
    wr(16'h8003, 8'h2C, "R9 2C zero");
    chk("R9 2C skips zero", win_e, 6'h08);
    wr(16'h8001, 8'h04, "R6 2C locked");

    wr(16'h8003, 8'h15, "R11 bad code");
    chk("R11 mode cleared", mode_active, 1'b0);
    wr(16'h8003, 8'hE6, "R11 upper bits ignored");
    chk("R12 active", mode_active, 1'b1);

    wr(16'h5180, 8'h80, "R12 outer high");
    chk("R12 bit5 merge", win_c[5], 1'b1);
    wr(16'h8000, 8'h2A, "R13 8000");
    wr(16'h8002, 8'h15, "R13 8002");
    wr(16'hA001, 8'h15, "R13 A001");
    wr(16'h6000, 8'h2A, "R13 6000");
    wr(16'hC003, 8'h15, "R13 C003");

    for (int n = 0; n < 3000; n++) begin
      int unsigned k;
      k = $urandom_range(0, 9);
      d = 8'($urandom);
      case (k)
        0: a = 16'h5000 | 16'($urandom_range(0, 16'h0FFF));
        1: a = 16'h5180 | 16'($urandom_range(0, 16'h0E7F));
        2, 3: a = 16'h8001 | (16'($urandom_range(0, 16'h07FF)) << 2);
        4, 5: begin
          a = 16'h8003 | (16'($urandom_range(0, 16'h07FF)) << 2);
          case ($urandom_range(0, 10))
            0: d[5:0] = 6'h20; 1: d[5:0] = 6'h26; 2: d[5:0] = 6'h28;
            3: d[5:0] = 6'h29; 4: d[5:0] = 6'h2A; 5: d[5:0] = 6'h2B;
            6: d[5:0] = 6'h2C; 7: d[5:0] = 6'h2F; 8: d[5:0] = 6'h3C;
            9: d[5:0] = 6'h3F; default: ;
          endcase
        end
        6: a = 16'h8000 | (16'($urandom_range(0, 16'h07FF)) << 2) | 16'($urandom_range(0, 1) * 2);
        default: a = 16'($urandom);
      endcase
      wr(a, d, "R12 random write");
      if (k == 0) rd(16'h5000 | 16'($urandom_range(0, 16'h0FFF)), "R2 random read");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule